// File: doc/BRIEF.md
# Scatter-Gather Receive Stream Writer

This block moves an incoming word stream into memory. The buffers it fills are described by a chain of descriptors held in memory. The engine fetches the descriptor at the current pointer and accepts stream beats into that descriptor's buffer until the buffer is full or the packet ends. It then writes a status word back into the descriptor and moves the current pointer to the next descriptor in the chain. A packet longer than one buffer continues into as many following descriptors as it needs. The status word marks the first and the last descriptor of each packet.

A separate sideband stream carries five application words for each packet. The engine keeps the most recent well-formed set of five words. It copies that set into the descriptor that holds the end of a packet.

The surrounding logic controls the engine through three things:
- a run level;
- a start pulse, which loads the current pointer;
- a tail pointer, with a pulse that marks the tail as moved.

When the engine completes the tail descriptor it goes idle. While it is stopped, halted or idle it accepts no stream data. Each completed descriptor produces a one-cycle pulse, which a later coalescing stage can count.

Top module: `rxsg_engine`

## Requirements
- R1: After reset `halted` is 1, `idle` is 0, and both `sDataReady` and `descDone` are 0.
- R2: A `chanStart` pulse while the engine is waiting loads `curPtr` from `startPtr` and clears `halted` and `idle`. `sDataReady` is 1 only while `run` is 1, the engine is neither halted nor idle, and a fetched descriptor has buffer space left.
- R3: The descriptor fields sit at fixed byte offsets from its base address: next pointer at 0x00, buffer address at 0x08, control word at 0x18, status word at 0x1C, and the five application words at 0x20 to 0x30. The length is taken from control bits 22:0.
- R4: If the fetched status word has bit 31 set, the engine sets `halted`. It then accepts no beats and writes neither the buffer nor the status word.
- R5: Accepted beats are written to consecutive words of the buffer, starting at the buffer address. A descriptor receives at most length/4 words, and the rest of the packet continues into the following descriptors.
- R6: The status written back has bit 31 set and the received byte count in bits 22:0. Bit 27 is set on the first descriptor of a packet and bit 26 on the descriptor that received the packet's last beat.
- R7: The descriptor with bit 26 set also receives the latched application words at offsets 0x20 to 0x30, in arrival order.
- R8: A sideband frame is latched only if `cLast` arrives on its fifth word. Shorter or longer frames leave the previously latched words unchanged.
- R9: After each status write, `curPtr` becomes the fetched next pointer. If the finished descriptor was at `tailPtr`, `idle` is set and `sDataReady` stays 0.
- R10: A `tailBump` pulse clears `idle`, so reception resumes at `curPtr`.
- R11: `descDone` pulses for exactly one cycle per completed descriptor.
- R12: While `run` is 0, no beat is accepted and no descriptor completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel run level |
| chanStart | input | 1 | Pulse: load current pointer and clear halted and idle |
| startPtr | input | ADDR_W | First descriptor address |
| tailPtr | input | ADDR_W | Tail descriptor address |
| tailBump | input | 1 | Pulse: tail moved, clear idle |
| sDataValid | input | 1 | Data stream valid |
| sDataReady | output | 1 | Data stream ready |
| sData | input | 32 | Data stream word |
| sDataLast | input | 1 | Last beat of a packet |
| cValid | input | 1 | Sideband word valid |
| cReady | output | 1 | Sideband ready (always 1) |
| cData | input | 32 | Sideband word |
| cLast | input | 1 | Last sideband word of a frame |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, one cycle after a read |
| curPtr | output | ADDR_W | Current descriptor pointer |
| idle | output | 1 | Tail descriptor completed |
| halted | output | 1 | Engine halted |
| descDone | output | 1 | One-cycle descriptor completion pulse |

## Verification
The assertions check these properties on every cycle:
- the ready gating against run, idle and halted;
- the single-cycle width of the completion pulse;
- that every accepted beat is a memory write;
- that the pointer and the halted flag hold while halted;
- that idle rises only right after a completion.

Only the bench scenarios can show the contents of memory:
- the status words, with their start and end flags and byte counts;
- packets split across several descriptors;
- the application words on the last descriptor;
- that malformed sideband frames are rejected;
- resuming after a tail move.

// File: rtl/rxsg_pkg.sv
`timescale 1ns/1ps
package rxsg_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 23;
  localparam int APP_WORDS = 5;
  localparam int STAT_DONE_BIT = 31;
  localparam int STAT_SOF_BIT  = 27;
  localparam int STAT_EOF_BIT  = 26;
  localparam logic [7:0] OFS_NEXT = 8'h00;
  localparam logic [7:0] OFS_BUF  = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h1C;
  localparam logic [7:0] OFS_APP  = 8'h20;

  typedef enum logic [2:0] {ST_OFF, ST_FETCH, ST_RECV, ST_STAT, ST_APP, ST_NEXT} engState_t;

  typedef struct packed {
    logic       loadStart;
    logic       rdEn;
    logic [1:0] rdSel;
    logic       capEn;
    logic [1:0] capSel;
    logic       beatWr;
    logic       statWr;
    logic       appWr;
    logic [2:0] appSel;
    logic       advance;
    logic       sofFlag;
    logic       eofFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/rxsg_ctrl.sv
`timescale 1ns/1ps
module rxsg_ctrl
  import rxsg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         chanStart,
  input  logic         tailBump,
  input  logic         sDataValid,
  input  logic         sDataLast,
  input  logic         rdDoneBit,
  input  logic         capEmpty,
  input  logic         lastSlot,
  input  logic         curIsTail,
  output ctrlStrobes_t st,
  output logic         sDataReady,
  output logic         idle,
  output logic         halted,
  output logic         descDone
);
  localparam logic [2:0] FETCH_LAST = 3'd4;
  localparam logic [2:0] APP_LAST   = 3'(APP_WORDS - 1);

  engState_t  state;
  logic [2:0] fetchCnt;
  logic [2:0] appCnt;
  logic       sofPending;
  logic       eofSeen;

  always_comb begin
    st           = '0;
    st.loadStart = (state == ST_OFF) && chanStart;
    st.rdEn      = (state == ST_FETCH) && (fetchCnt != FETCH_LAST);
    st.rdSel     = fetchCnt[1:0];
    st.capEn     = (state == ST_FETCH) && (fetchCnt != 3'd0);
    st.capSel    = 2'(fetchCnt - 3'd1);
    // R2 R12: ready only in reception, running, not idle or halted, with space
    sDataReady   = (state == ST_RECV) && run && !idle && !halted && !capEmpty;
    st.beatWr    = sDataReady && sDataValid;
    st.statWr    = (state == ST_STAT);
    st.appWr     = (state == ST_APP);
    st.appSel    = appCnt;
    st.advance   = (state == ST_NEXT);
    st.sofFlag   = sofPending;
    st.eofFlag   = eofSeen;
    descDone     = (state == ST_NEXT);  // R11
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_OFF;
      fetchCnt   <= '0;
      appCnt     <= '0;
      sofPending <= 1'b1;
      eofSeen    <= 1'b0;
      idle       <= 1'b0;
      halted     <= 1'b1;   // R1
    end else begin
      // R9 R10: idle set on tail completion, cleared by tail move or start
      if (tailBump || st.loadStart) idle <= 1'b0;
      else if (state == ST_NEXT && curIsTail) idle <= 1'b1;

      case (state)
        ST_OFF: begin
          if (st.loadStart) begin
            halted     <= 1'b0;
            sofPending <= 1'b1;
          end else if (run && !halted && !idle) begin
            state    <= ST_FETCH;
            fetchCnt <= '0;
          end
        end
        ST_FETCH: begin
          fetchCnt <= fetchCnt + 3'd1;
          if (fetchCnt == FETCH_LAST) begin
            if (rdDoneBit) begin   // R4
              halted <= 1'b1;
              state  <= ST_OFF;
            end else begin
              state <= ST_RECV;
            end
          end
        end
        ST_RECV: begin
          if (capEmpty) begin
            eofSeen <= 1'b0;
            state   <= ST_STAT;
          end else if (st.beatWr && (sDataLast || lastSlot)) begin
            eofSeen <= sDataLast;
            state   <= ST_STAT;
          end
        end
        ST_STAT: begin
          if (eofSeen) begin
            appCnt <= '0;
            state  <= ST_APP;
          end else begin
            state <= ST_NEXT;
          end
        end
        ST_APP: begin
          appCnt <= appCnt + 3'd1;
          if (appCnt == APP_LAST) state <= ST_NEXT;
        end
        ST_NEXT: begin
          sofPending <= eofSeen | (sofPending & capEmpty);
          state      <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/rxsg_datapath.sv
`timescale 1ns/1ps
module rxsg_datapath
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      st,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] tailPtr,
  input  logic [WORD_W-1:0] sData,
  input  logic              cValid,
  input  logic              cLast,
  input  logic [WORD_W-1:0] cData,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] curPtr,
  output logic              rdDoneBit,
  output logic              capEmpty,
  output logic              lastSlot,
  output logic              curIsTail
);
  localparam int BYTE_SH = $clog2(WORD_W / 8);
  localparam int CNT_W   = LEN_W - BYTE_SH;
  localparam logic [2:0] SLOT_LAST = 3'(APP_WORDS - 1);

  logic [ADDR_W-1:0] nextPtr, bufPtr, rdOffset;
  logic [LEN_W-1:0]  lenBytes;
  logic [CNT_W-1:0]  beatCnt, capWords;
  logic [WORD_W-1:0] statWord;
  logic [WORD_W-1:0] appRegs [APP_WORDS];
  logic [WORD_W-1:0] stage   [APP_WORDS-1];
  logic [2:0]        slot;

  assign capWords  = lenBytes[LEN_W-1:BYTE_SH];
  assign capEmpty  = (capWords == '0);
  assign lastSlot  = ((beatCnt + CNT_W'(1)) == capWords);
  assign curIsTail = (curPtr == tailPtr);
  assign rdDoneBit = memRdata[STAT_DONE_BIT];

  // R3 R9: pointer and descriptor field capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr   <= '0;
      nextPtr  <= '0;
      bufPtr   <= '0;
      lenBytes <= '0;
      beatCnt  <= '0;
    end else begin
      if (st.loadStart) begin
        curPtr  <= startPtr;
        beatCnt <= '0;
      end else if (st.advance) begin
        curPtr  <= nextPtr;
        beatCnt <= '0;
      end else if (st.beatWr) begin
        beatCnt <= beatCnt + CNT_W'(1);
      end
      if (st.capEn) begin
        case (st.capSel)
          2'd0:    nextPtr  <= memRdata[ADDR_W-1:0];
          2'd1:    bufPtr   <= memRdata[ADDR_W-1:0];
          2'd2:    lenBytes <= memRdata[LEN_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R8: sideband words staged, committed only on a five-word frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot <= '0;
      for (int i = 0; i < APP_WORDS; i++) appRegs[i] <= '0;
      for (int i = 0; i < APP_WORDS - 1; i++) stage[i] <= '0;
    end else if (cValid) begin
      if (cLast) begin
        if (slot == SLOT_LAST) begin
          for (int i = 0; i < APP_WORDS - 1; i++) appRegs[i] <= stage[i];
          appRegs[APP_WORDS-1] <= cData;
        end
        slot <= '0;
      end else begin
        if (slot < SLOT_LAST) stage[slot[1:0]] <= cData;
        if (slot <= SLOT_LAST) slot <= slot + 3'd1;
      end
    end
  end

  always_comb begin
    case (st.rdSel)
      2'd0:    rdOffset = ADDR_W'(OFS_NEXT);
      2'd1:    rdOffset = ADDR_W'(OFS_BUF);
      2'd2:    rdOffset = ADDR_W'(OFS_CTRL);
      default: rdOffset = ADDR_W'(OFS_STAT);
    endcase
  end

  // R6: status word composition
  always_comb begin
    statWord                = '0;
    statWord[LEN_W-1:0]     = {beatCnt, {BYTE_SH{1'b0}}};
    statWord[STAT_EOF_BIT]  = st.eofFlag;
    statWord[STAT_SOF_BIT]  = st.sofFlag;
    statWord[STAT_DONE_BIT] = 1'b1;
  end

  // R5 R7: memory port multiplexer
  always_comb begin
    memEn    = st.rdEn | st.beatWr | st.statWr | st.appWr;
    memWe    = st.beatWr | st.statWr | st.appWr;
    memAddr  = curPtr + rdOffset;
    memWdata = sData;
    if (st.beatWr) begin
      memAddr = bufPtr + ADDR_W'({beatCnt, {BYTE_SH{1'b0}}});
    end else if (st.statWr) begin
      memAddr  = curPtr + ADDR_W'(OFS_STAT);
      memWdata = statWord;
    end else if (st.appWr) begin
      memAddr  = curPtr + ADDR_W'(OFS_APP) + ADDR_W'({st.appSel, {BYTE_SH{1'b0}}});
      memWdata = appRegs[st.appSel];
    end
  end
endmodule

// File: rtl/rxsg_engine.sv
`timescale 1ns/1ps
module rxsg_engine
  import rxsg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              chanStart,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] tailPtr,
  input  logic              tailBump,
  input  logic              sDataValid,
  output logic              sDataReady,
  input  logic [31:0]       sData,
  input  logic              sDataLast,
  input  logic              cValid,
  output logic              cReady,
  input  logic [31:0]       cData,
  input  logic              cLast,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] curPtr,
  output logic              idle,
  output logic              halted,
  output logic              descDone
);
  ctrlStrobes_t st;
  logic rdDoneBit, capEmpty, lastSlot, curIsTail;

  assign cReady = 1'b1;

  rxsg_ctrl u_ctrl (
    .clk, .rstN, .run, .chanStart, .tailBump, .sDataValid, .sDataLast,
    .rdDoneBit, .capEmpty, .lastSlot, .curIsTail,
    .st, .sDataReady, .idle, .halted, .descDone
  );

  rxsg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk, .rstN, .st, .startPtr, .tailPtr, .sData, .cValid, .cLast, .cData,
    .memRdata, .memEn, .memWe, .memAddr, .memWdata, .curPtr,
    .rdDoneBit, .capEmpty, .lastSlot, .curIsTail
  );
endmodule

// File: rtl/rxsg_engine_chk.sv
`timescale 1ns/1ps
module rxsg_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              chanStart,
  input logic              sDataValid,
  input logic              sDataReady,
  input logic              memEn,
  input logic              memWe,
  input logic              idle,
  input logic              halted,
  input logic              descDone,
  input logic [ADDR_W-1:0] curPtr
);
  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sDataReady |-> (run && !idle && !halted));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    descDone |=> !descDone);

  // R5
  beat_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sDataValid && sDataReady) |-> (memEn && memWe));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !chanStart) |=> (halted && $stable(curPtr)));

  // R9
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> $past(descDone));

  // R12
  stop_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !sDataReady);
endmodule

bind rxsg_engine rxsg_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .chanStart(chanStart),
  .sDataValid(sDataValid), .sDataReady(sDataReady), .memEn(memEn),
  .memWe(memWe), .idle(idle), .halted(halted), .descDone(descDone),
  .curPtr(curPtr)
);

// File: tb/rxsg_engine_bench.sv
`timescale 1ns/1ps
module rxsg_engine_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, run = 1'b0, chanStart = 1'b0, tailBump = 1'b0;
  logic [31:0] startPtr = '0, tailPtr = '0;
  logic sDataValid = 1'b0, sDataLast = 1'b0, cValid = 1'b0, cLast = 1'b0;
  logic [31:0] sData = '0, cData = '0;
  logic sDataReady, cReady, memEn, memWe, idle, halted, descDone;
  logic [31:0] memAddr, memWdata, curPtr;
  logic [31:0] memRdata = '0;
  logic [31:0] mem [0:1023];

  rxsg_engine u_rxsg_engine (
    .clk, .rstN, .run, .chanStart, .startPtr, .tailPtr, .tailBump,
    .sDataValid, .sDataReady, .sData, .sDataLast, .cValid, .cReady, .cData,
    .cLast, .memEn, .memWe, .memAddr, .memWdata, .memRdata, .curPtr, .idle,
    .halted, .descDone
  );

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr[11:2]] <= memWdata;
      else memRdata <= mem[memAddr[11:2]];
    end
  end

  int passCnt = 0, failCnt = 0, doneCnt = 0;
  always @(negedge clk) if (rstN && descDone) doneCnt++;

  localparam int NVEC = 5;
  localparam int VEC_BEATS [NVEC] = '{4, 10, 8, 1, 7};
  localparam int VEC_LEN   [NVEC] = '{64, 16, 16, 4, 12};

  function automatic logic [31:0] dAddr(input int i);
    return 32'(i * 64);
  endfunction
  function automatic logic [31:0] bAddr(input int i);
    return 32'h800 + 32'(i * 256);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setupChain(input int first, input int n, input int lenBytes);
    for (int i = first; i < first + n; i++) begin
      for (int k = 0; k < 16; k++) mem[i*16 + k] = '0;
      mem[i*16 + 0] = dAddr(i + 1);
      mem[i*16 + 2] = bAddr(i);
      mem[i*16 + 6] = 32'(lenBytes);
      for (int w = 0; w < 64; w++) mem[bAddr(i)/4 + w] = '0;
    end
  endtask

  task automatic sendBeat(input logic [31:0] d, input bit last);
    sDataValid = 1'b1; sData = d; sDataLast = last;
    while (!sDataReady) @(negedge clk);
    @(negedge clk);
    sDataValid = 1'b0; sDataLast = 1'b0;
  endtask

  task automatic sendCtrl(input int n, input logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      cValid = 1'b1; cData = base + 32'(k); cLast = (k == n - 1);
      @(negedge clk);
    end
    cValid = 1'b0; cLast = 1'b0;
  endtask

  task automatic startChan(input logic [31:0] p);
    startPtr = p; chanStart = 1'b1;
    @(negedge clk);
    chanStart = 1'b0;
  endtask

  task automatic waitIdle();
    while (!idle) @(negedge clk);
  endtask

  task automatic checkDesc(input int di, input int bytes, input bit sof, input bit eof,
                           input logic [31:0] firstBeat, input logic [31:0] appBase);
    logic [31:0] exp;
    int bad;
    exp = 32'h8000_0000 | (32'(sof) << 27) | (32'(eof) << 26) | 32'(bytes);
    check(mem[di*16 + 7] == exp, "R6 status", mem[di*16 + 7], exp);
    bad = 0;
    for (int w = 0; w < bytes / 4; w++)
      if (mem[bAddr(di)/4 + w] != firstBeat + 32'(w)) bad++;
    check(bad == 0, "R3 R5 buffer words", 32'(bad), 32'd0);
    if (eof) begin
      bad = 0;
      for (int k = 0; k < 5; k++)
        if (mem[di*16 + 8 + k] != appBase + 32'(k)) bad++;
      check(bad == 0, "R7 app words", 32'(bad), 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(halted == 1'b1 && idle == 1'b0, "R1 flags", {30'd0, halted, idle}, 32'd2);
    check(!sDataReady && !descDone, "R1 outputs", {30'd0, sDataReady, descDone}, 32'd0);
    run = 1'b1;
    repeat (3) @(negedge clk);
    check(!sDataReady, "R2 no ready before start", {31'd0, sDataReady}, 32'd0);

    // table-driven packets
    for (int v = 0; v < NVEC; v++) begin
      int capW, n, d0, rem, bytes;
      logic [31:0] base, appBase;
      capW = VEC_LEN[v] / 4;
      n = (VEC_BEATS[v] + capW - 1) / capW;
      base = 32'hA000_0000 + 32'(v * 256);
      appBase = 32'hC000_0000 + 32'(v * 16);
      setupChain(0, n, VEC_LEN[v]);
      tailPtr = dAddr(n - 1);
      sendCtrl(5, appBase);
      d0 = doneCnt;
      startChan(dAddr(0));
      for (int b = 0; b < VEC_BEATS[v]; b++) sendBeat(base + 32'(b), b == VEC_BEATS[v] - 1);
      waitIdle();
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        rem = VEC_BEATS[v] - k * capW;
        bytes = (rem < capW ? rem : capW) * 4;
        checkDesc(k, bytes, k == 0, k == n - 1, base + 32'(k * capW), appBase);
      end
      check(curPtr == dAddr(n), "R9 pointer advance", curPtr, dAddr(n));
      check(doneCnt - d0 == n, "R11 completion pulses", 32'(doneCnt - d0), 32'(n));
      check(!sDataReady, "R9 idle blocks data", {31'd0, sDataReady}, 32'd0);
    end

    // R12: stopped channel takes nothing
    begin
      int d0;
      setupChain(0, 1, 16);
      tailPtr = dAddr(0);
      run = 1'b0;
      sendCtrl(5, 32'hD000_0000);
      d0 = doneCnt;
      startChan(dAddr(0));
      sDataValid = 1'b1; sData = 32'h5555_0000;
      repeat (12) @(negedge clk);
      check(!sDataReady && doneCnt == d0, "R12 stopped", {31'd0, sDataReady}, 32'd0);
      check(mem[bAddr(0)/4] == 32'd0, "R12 buffer untouched", mem[bAddr(0)/4], 32'd0);
      sDataValid = 1'b0;
      run = 1'b1;
      sendBeat(32'h5555_0000, 1'b0);
      sendBeat(32'h5555_0001, 1'b1);
      waitIdle();
      @(negedge clk);
      checkDesc(0, 8, 1'b1, 1'b1, 32'h5555_0000, 32'hD000_0000);
    end

    // R8: malformed sideband frames ignored
    sendCtrl(3, 32'hE000_0000);
    sendCtrl(6, 32'hF000_0000);
    setupChain(0, 1, 16);
    tailPtr = dAddr(0);
    startChan(dAddr(0));
    sendBeat(32'h6666_0000, 1'b1);
    waitIdle();
    @(negedge clk);
    check(mem[8] == 32'hD000_0000 && mem[12] == 32'hD000_0004, "R8 last good frame kept",
          mem[8], 32'hD000_0000);

    // R4: descriptor already complete halts the engine
    begin
      int d0;
      setupChain(0, 1, 16);
      mem[7] = 32'h8000_0010;
      mem[bAddr(0)/4] = 32'h1234_5678;
      tailPtr = dAddr(0);
      d0 = doneCnt;
      startChan(dAddr(0));
      sDataValid = 1'b1; sData = 32'h7777_0000; sDataLast = 1'b1;
      repeat (12) @(negedge clk);
      check(halted && !sDataReady, "R4 halted", {30'd0, halted, sDataReady}, 32'd2);
      check(mem[7] == 32'h8000_0010, "R4 status untouched", mem[7], 32'h8000_0010);
      check(mem[bAddr(0)/4] == 32'h1234_5678 && doneCnt == d0, "R4 buffer untouched",
            mem[bAddr(0)/4], 32'h1234_5678);
      sDataValid = 1'b0; sDataLast = 1'b0;
    end

    // R9 R10: idle at tail, tail move resumes
    setupChain(0, 2, 16);
    tailPtr = dAddr(0);
    sendCtrl(5, 32'hB000_0000);
    startChan(dAddr(0));
    for (int b = 0; b < 4; b++) sendBeat(32'h8888_0000 + 32'(b), b == 3);
    waitIdle();
    repeat (3) @(negedge clk);
    check(curPtr == dAddr(1) && idle && !sDataReady, "R9 idle at tail", curPtr, dAddr(1));
    checkDesc(0, 16, 1'b1, 1'b1, 32'h8888_0000, 32'hB000_0000);
    tailPtr = dAddr(1);
    tailBump = 1'b1;
    @(negedge clk);
    tailBump = 1'b0;
    check(!idle, "R10 idle cleared", {31'd0, idle}, 32'd0);
    sendBeat(32'h9999_0000, 1'b0);
    sendBeat(32'h9999_0001, 1'b1);
    waitIdle();
    @(negedge clk);
    checkDesc(1, 8, 1'b1, 1'b1, 32'h9999_0000, 32'hB000_0000);
    check(curPtr == dAddr(2), "R10 resumed advance", curPtr, dAddr(2));

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule